// File: doc/BRIEF.md
# Scan-Based Logic Self-Test Controller

This block runs a complete logic self-test over a set of parallel scan chains without any outside tester. A start request puts it in test mode: it stops functional clocking, takes over scan enable, and loads a 32-bit pseudo-random generator with a fixed seed. An XOR network mixes generator stages into one input per chain. The controller fills the chains, pulses one functional capture cycle and then moves the captured responses out. A 32-bit multiple-input signature register folds the responses into one word.

While one pattern shifts in, the responses of the previous pattern shift out, so each pattern after the first costs one chain length plus one capture cycle. One unload-only phase follows the last capture. The final signature is then compared with a golden value supplied as a parameter, and one latched pass or fail flag gives the result. The chains and the logic they surround sit outside the block. The pattern count, chain length, seed and golden signature are parameters.

Top module: `lbist_ctrl`

## Requirements
- R1: While not busy, scan_en and cap_en are low. A start_req sampled while not busy raises busy on the next clock edge and clears pass and fail. It loads the generator with SEED and the signature register with all ones.
- R2: The generator is a 32-bit Fibonacci LFSR shifting toward the MSB. Its new bit 0 is s[31]^s[21]^s[1]^s[0], for the polynomial x^32+x^22+x^2+x+1. It advances once per shift-phase cycle and holds in every other cycle.
- R3: In a shift-phase cycle, chain_si[c] is s[(7c)%32] ^ s[(7c+11)%32] ^ s[(7c+23)%32] of the current generator state s. In every other cycle, chain_si is all zeros.
- R4: Each pattern begins with a shift phase of exactly CHAIN_LEN cycles with scan_en high and cap_en low. The first shift phase starts in the cycle after the start request.
- R5: Each shift phase is followed by exactly one capture cycle with scan_en low and cap_en high. Scan_en and cap_en are never high together.
- R6: The signature register is a 32-bit Galois register shifting toward the MSB with feedback mask 0x00400007. chain_so[c] is XORed into stage c*(32/NUM_CHAINS) on every compaction cycle. Compaction happens in every shift cycle except those of the first pattern, and in every unload cycle.
- R7: After the last of NUM_PATTERNS captures, an unload phase of CHAIN_LEN cycles runs with scan_en high, cap_en low and chain_si zero.
- R8: One verdict cycle with scan_en and cap_en low follows the unload. At its end busy falls and exactly one of pass or fail rises. Pass rises only if the signature equals GOLDEN.
- R9: Pass and fail stay unchanged until the next accepted start_req. A start_req while busy has no effect on the sequence.
- R10: If the generator holds the all-zero state in any busy cycle, the verdict is fail, whatever the signature.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Requests a self-test run |
| chain_so | input | NUM_CHAINS | Serial outputs of the scan chains |
| chain_si | output | NUM_CHAINS | Serial inputs to the scan chains |
| scan_en | output | 1 | Scan enable, high while chains shift |
| cap_en | output | 1 | Functional capture clock enable |
| busy | output | 1 | Self-test in progress |
| pass | output | 1 | Latched verdict: signature matched |
| fail | output | 1 | Latched verdict: mismatch or locked generator |

## Verification
The assertions check the control protocol on every cycle. They cover idle silence on scan and capture enables, a single-cycle capture that never overlaps scan enable, and the pass/fail exclusion. They also check that no verdict shows while busy, that the verdict holds while idle, and that exactly one flag rises when busy falls. Only the bench can show the data path: the mixed generator stream on each chain input, the shift and unload lengths, and whether the compacted signature matches the golden value. The bench shows this with a chain model and a golden value it computes itself. It also shows that a one-bit golden change and a zero seed both end in fail.

// File: rtl/lbist_pkg.sv
package lbist_pkg;

    localparam int GEN_W = 32;
    localparam int SIG_W = 32;
    localparam logic [SIG_W-1:0] SIG_MASK = 32'h0040_0007;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_CAPTURE,
        ST_UNLOAD,
        ST_VERDICT
    } lbist_state_e;

    typedef struct packed {
        logic scan_en;
        logic cap_en;
        logic gen_load;
        logic gen_adv;
        logic gen_mute;
        logic sig_load;
        logic sig_comp;
    } lbist_ctl_t;

    function automatic logic [GEN_W-1:0] gen_step(input logic [GEN_W-1:0] s);
        return {s[GEN_W-2:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    function automatic logic [SIG_W-1:0] sig_step(input logic [SIG_W-1:0] m,
                                                  input logic [SIG_W-1:0] inj);
        return {m[SIG_W-2:0], 1'b0} ^ (m[SIG_W-1] ? SIG_MASK : '0) ^ inj;
    endfunction

    function automatic int unsigned mix_tap(input int unsigned ch, input int unsigned k);
        int unsigned offs;
        offs = (k == 0) ? 0 : ((k == 1) ? 11 : 23);
        return (7 * ch + offs) % GEN_W;
    endfunction

endpackage

// File: rtl/lbist_prpg.sv
module lbist_prpg
    import lbist_pkg::*;
#(
    parameter int NUM_CHAINS = 4,
    parameter logic [GEN_W-1:0] SEED = 32'h1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  logic                  adv,
    input  logic                  mute,
    output logic [NUM_CHAINS-1:0] mix_out,
    output logic                  is_zero
);
    logic [GEN_W-1:0] gen_q;

    always_ff @(posedge clk) begin
        if (rst)
            gen_q <= SEED;
        else if (load)
            gen_q <= SEED;
        else if (adv)
            gen_q <= gen_step(gen_q);
    end

    assign is_zero = (gen_q == '0);

    for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_mix
        localparam int unsigned TA = mix_tap(c, 0);
        localparam int unsigned TB = mix_tap(c, 1);
        localparam int unsigned TC = mix_tap(c, 2);
        assign mix_out[c] = !mute & (gen_q[TA] ^ gen_q[TB] ^ gen_q[TC]);
    end
endmodule

// File: rtl/lbist_misr.sv
module lbist_misr
    import lbist_pkg::*;
#(
    parameter int NUM_CHAINS = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  logic                  comp,
    input  logic [NUM_CHAINS-1:0] resp,
    output logic [SIG_W-1:0]      sig
);
    localparam int STRIDE = SIG_W / NUM_CHAINS;

    logic [SIG_W-1:0] inj;

    always_comb begin
        inj = '0;
        for (int c = 0; c < NUM_CHAINS; c++)
            inj[c * STRIDE] = resp[c];
    end

    always_ff @(posedge clk) begin
        if (rst)
            sig <= '1;
        else if (load)
            sig <= '1;
        else if (comp)
            sig <= sig_step(sig, inj);
    end
endmodule

// File: rtl/lbist_seq.sv
module lbist_seq
    import lbist_pkg::*;
#(
    parameter int CHAIN_LEN    = 8,
    parameter int NUM_PATTERNS = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_req,
    input  logic       sig_match,
    input  logic       gen_zero,
    output lbist_ctl_t ctl,
    output logic       busy,
    output logic       pass,
    output logic       fail
);
    localparam int CW = $clog2(CHAIN_LEN + 1);
    localparam int PW = $clog2(NUM_PATTERNS + 1);
    localparam logic [CW-1:0] LAST_BIT = CW'(CHAIN_LEN - 1);
    localparam logic [PW-1:0] LAST_PAT = PW'(NUM_PATTERNS - 1);

    lbist_state_e state;
    logic [CW-1:0] bit_cnt;
    logic [PW-1:0] pat_cnt;
    logic          zero_seen;

    always_comb begin
        ctl          = '0;
        ctl.scan_en  = (state == ST_SHIFT) || (state == ST_UNLOAD);
        ctl.cap_en   = (state == ST_CAPTURE);
        ctl.gen_load = (state == ST_IDLE) && start_req;
        ctl.sig_load = (state == ST_IDLE) && start_req;
        ctl.gen_adv  = (state == ST_SHIFT);
        ctl.gen_mute = (state != ST_SHIFT);
        ctl.sig_comp = ((state == ST_SHIFT) && (pat_cnt != '0)) || (state == ST_UNLOAD);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            bit_cnt   <= '0;
            pat_cnt   <= '0;
            busy      <= 1'b0;
            pass      <= 1'b0;
            fail      <= 1'b0;
            zero_seen <= 1'b0;
        end else begin
            if (busy && gen_zero)
                zero_seen <= 1'b1;
            unique case (state)
                ST_IDLE: begin
                    if (start_req) begin
                        state     <= ST_SHIFT;
                        bit_cnt   <= '0;
                        pat_cnt   <= '0;
                        busy      <= 1'b1;
                        pass      <= 1'b0;
                        fail      <= 1'b0;
                        zero_seen <= 1'b0;
                    end
                end
                ST_SHIFT: begin
                    if (bit_cnt == LAST_BIT) begin
                        bit_cnt <= '0;
                        state   <= ST_CAPTURE;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                ST_CAPTURE: begin
                    pat_cnt <= pat_cnt + 1'b1;
                    state   <= (pat_cnt == LAST_PAT) ? ST_UNLOAD : ST_SHIFT;
                end
                ST_UNLOAD: begin
                    if (bit_cnt == LAST_BIT) begin
                        bit_cnt <= '0;
                        state   <= ST_VERDICT;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                ST_VERDICT: begin
                    pass  <= sig_match && !zero_seen && !gen_zero;
                    fail  <= !(sig_match && !zero_seen && !gen_zero);
                    busy  <= 1'b0;
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/lbist_ctrl.sv
module lbist_ctrl
    import lbist_pkg::*;
#(
    parameter int NUM_CHAINS   = 4,
    parameter int CHAIN_LEN    = 8,
    parameter int NUM_PATTERNS = 6,
    parameter logic [GEN_W-1:0] SEED   = 32'h1,
    parameter logic [SIG_W-1:0] GOLDEN = 32'h0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start_req,
    input  logic [NUM_CHAINS-1:0] chain_so,
    output logic [NUM_CHAINS-1:0] chain_si,
    output logic                  scan_en,
    output logic                  cap_en,
    output logic                  busy,
    output logic                  pass,
    output logic                  fail
);
    lbist_ctl_t       ctl;
    logic             gen_zero;
    logic [SIG_W-1:0] sig;

    lbist_seq #(
        .CHAIN_LEN   (CHAIN_LEN),
        .NUM_PATTERNS(NUM_PATTERNS)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start_req(start_req),
        .sig_match(sig == GOLDEN),
        .gen_zero (gen_zero),
        .ctl      (ctl),
        .busy     (busy),
        .pass     (pass),
        .fail     (fail)
    );

    lbist_prpg #(
        .NUM_CHAINS(NUM_CHAINS),
        .SEED      (SEED)
    ) u_prpg (
        .clk    (clk),
        .rst    (rst),
        .load   (ctl.gen_load),
        .adv    (ctl.gen_adv),
        .mute   (ctl.gen_mute),
        .mix_out(chain_si),
        .is_zero(gen_zero)
    );

    lbist_misr #(
        .NUM_CHAINS(NUM_CHAINS)
    ) u_misr (
        .clk (clk),
        .rst (rst),
        .load(ctl.sig_load),
        .comp(ctl.sig_comp),
        .resp(chain_so),
        .sig (sig)
    );

    assign scan_en = ctl.scan_en;
    assign cap_en  = ctl.cap_en;
endmodule

// File: rtl/lbist_ctrl_chk.sv
module lbist_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic start_req,
    input logic scan_en,
    input logic cap_en,
    input logic busy,
    input logic pass,
    input logic fail
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!scan_en && !cap_en)); // R1
    AST_START_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (!busy && start_req) |=> (busy && scan_en && !pass && !fail)); // R1
    AST_CAP_AFTER_SHIFT: assert property (@(posedge clk) disable iff (rst)
        cap_en |-> $past(scan_en)); // R4
    AST_CAP_SINGLE: assert property (@(posedge clk) disable iff (rst)
        cap_en |=> !cap_en); // R5
    AST_CAP_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(scan_en && cap_en)); // R5
    AST_VERDICT_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(pass && fail)); // R8
    AST_VERDICT_ON_EXIT: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (pass ^ fail)); // R8
    AST_NO_VERDICT_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |-> (!pass && !fail)); // R9
    AST_VERDICT_HELD: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start_req) |=> ($stable(pass) && $stable(fail) && !busy)); // R9
endmodule

bind lbist_ctrl lbist_ctrl_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .start_req(start_req),
    .scan_en  (scan_en),
    .cap_en   (cap_en),
    .busy     (busy),
    .pass     (pass),
    .fail     (fail)
);

// File: tb/lbist_ctrl_tb.sv
module lbist_ctrl_tb;
    localparam int NCH  = 4;
    localparam int LEN  = 8;
    localparam int NPAT = 6;
    localparam logic [31:0] SEEDV = 32'hACE1_2468;

    function automatic logic [31:0] b_gen(input logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    function automatic logic [NCH-1:0] b_mix(input logic [31:0] s);
        logic [NCH-1:0] r;
        for (int c = 0; c < NCH; c++)
            r[c] = s[(7*c) % 32] ^ s[(7*c + 11) % 32] ^ s[(7*c + 23) % 32];
        return r;
    endfunction

    function automatic logic [31:0] b_sig(input logic [31:0] m, input logic [NCH-1:0] so);
        logic [31:0] r;
        r = {m[30:0], 1'b0};
        if (m[31]) r = r ^ 32'h0040_0007;
        for (int c = 0; c < NCH; c++)
            r[c * (32 / NCH)] = r[c * (32 / NCH)] ^ so[c];
        return r;
    endfunction

    function automatic logic [NCH*LEN-1:0] b_shift(input logic [NCH*LEN-1:0] ch,
                                                   input logic [NCH-1:0] si);
        logic [NCH*LEN-1:0] r;
        for (int c = 0; c < NCH; c++)
            r[c*LEN +: LEN] = {ch[c*LEN +: LEN-1], si[c]};
        return r;
    endfunction

    function automatic logic [NCH*LEN-1:0] b_cap(input logic [NCH*LEN-1:0] ch);
        logic [NCH*LEN-1:0] r;
        logic [LEN-1:0] row;
        for (int c = 0; c < NCH; c++) begin
            row = ch[c*LEN +: LEN];
            r[c*LEN +: LEN] = {row[LEN-2:0], row[LEN-1]} ^ ~ch[((c+1) % NCH)*LEN +: LEN];
        end
        return r;
    endfunction

    function automatic logic [NCH-1:0] b_tail(input logic [NCH*LEN-1:0] ch);
        logic [NCH-1:0] r;
        for (int c = 0; c < NCH; c++)
            r[c] = ch[c*LEN + LEN - 1];
        return r;
    endfunction

    function automatic logic [31:0] calc_golden();
        logic [31:0] g;
        logic [31:0] m;
        logic [NCH*LEN-1:0] ch;
        g  = SEEDV;
        m  = '1;
        ch = '0;
        for (int p = 0; p < NPAT; p++) begin
            for (int k = 0; k < LEN; k++) begin
                if (p > 0) m = b_sig(m, b_tail(ch));
                ch = b_shift(ch, b_mix(g));
                g  = b_gen(g);
            end
            ch = b_cap(ch);
        end
        for (int k = 0; k < LEN; k++) begin
            m  = b_sig(m, b_tail(ch));
            ch = b_shift(ch, '0);
        end
        return m;
    endfunction

    localparam logic [31:0] GOLD = calc_golden();

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_req = 1'b0;
    logic [NCH-1:0] chain_so, si_d, si_b, si_z;
    logic se_d, ce_d, busy_d, pass_d, fail_d;
    logic se_b, ce_b, busy_b, pass_b, fail_b;
    logic se_z, ce_z, busy_z, pass_z, fail_z;
    logic [NCH*LEN-1:0] chains;

    int n_chk = 0;
    int n_err = 0;
    bit chk_on = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    lbist_ctrl #(.NUM_CHAINS(NCH), .CHAIN_LEN(LEN), .NUM_PATTERNS(NPAT),
                 .SEED(SEEDV), .GOLDEN(GOLD)) u_dut (
        .clk(clk), .rst(rst), .start_req(start_req), .chain_so(chain_so),
        .chain_si(si_d), .scan_en(se_d), .cap_en(ce_d),
        .busy(busy_d), .pass(pass_d), .fail(fail_d));

    lbist_ctrl #(.NUM_CHAINS(NCH), .CHAIN_LEN(LEN), .NUM_PATTERNS(NPAT),
                 .SEED(SEEDV), .GOLDEN(GOLD ^ 32'h1)) u_bad (
        .clk(clk), .rst(rst), .start_req(start_req), .chain_so(chain_so),
        .chain_si(si_b), .scan_en(se_b), .cap_en(ce_b),
        .busy(busy_b), .pass(pass_b), .fail(fail_b));

    lbist_ctrl #(.NUM_CHAINS(NCH), .CHAIN_LEN(LEN), .NUM_PATTERNS(NPAT),
                 .SEED(32'h0), .GOLDEN(GOLD)) u_zero (
        .clk(clk), .rst(rst), .start_req(start_req), .chain_so(chain_so),
        .chain_si(si_z), .scan_en(se_z), .cap_en(ce_z),
        .busy(busy_z), .pass(pass_z), .fail(fail_z));

    // scan chains around a small combinational cloud
    always @(posedge clk) begin
        if (rst)
            chains <= '0;
        else if (se_d)
            chains <= b_shift(chains, si_d);
        else if (ce_d)
            chains <= b_cap(chains);
    end
    assign chain_so = b_tail(chains);

    // behavioural reference: 0 idle, 1 shift, 2 capture, 3 unload, 4 verdict
    int m_ph = 0;
    int m_cnt = 0;
    int m_pat = 0;
    logic [31:0] m_gen = '0;
    logic m_busy = 1'b0;
    logic m_pass = 1'b0;
    logic m_fail = 1'b0;

    always @(posedge clk) begin
        if (rst) begin
            m_ph = 0; m_busy = 0; m_pass = 0; m_fail = 0;
        end else begin
            case (m_ph)
                0: if (start_req) begin
                       m_ph = 1; m_cnt = 0; m_pat = 0; m_gen = SEEDV;
                       m_busy = 1; m_pass = 0; m_fail = 0;
                   end
                1: begin
                       m_gen = b_gen(m_gen);
                       m_cnt++;
                       if (m_cnt == LEN) begin m_cnt = 0; m_ph = 2; end
                   end
                2: begin
                       m_pat++;
                       m_ph = (m_pat == NPAT) ? 3 : 1;
                   end
                3: begin
                       m_cnt++;
                       if (m_cnt == LEN) begin m_cnt = 0; m_ph = 4; end
                   end
                default: begin
                       m_ph = 0; m_busy = 0; m_pass = 1; m_fail = 0;
                   end
            endcase
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (chk_on) begin
            chk("R4 R7 scan_en", 64'(se_d), 64'((m_ph == 1) || (m_ph == 3)));
            chk("R5 cap_en", 64'(ce_d), 64'(m_ph == 2));
            chk("R2 R3 chain_si", 64'(si_d), (m_ph == 1) ? 64'(b_mix(m_gen)) : 64'h0);
            chk("R1 busy", 64'(busy_d), 64'(m_busy));
            chk("R9 pass", 64'(pass_d), 64'(m_pass));
            chk("R9 fail", 64'(fail_d), 64'(m_fail));
        end
    end

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        cycles(3);
        chk("R1 reset busy", 64'(busy_d), 64'h0);
        chk("R1 reset scan_en", 64'(se_d), 64'h0);
        chk("R1 reset verdict", 64'({pass_d, fail_d}), 64'h0);
        rst = 1'b0;
        chk_on = 1'b1;
        cycles(2);

        // run 1, with stray requests in shift and in unload
        start_req = 1'b1; cycles(1); start_req = 1'b0;
        cycles(20);
        start_req = 1'b1; cycles(1); start_req = 1'b0;
        cycles(37);
        start_req = 1'b1; cycles(1); start_req = 1'b0;
        cycles(15);
        chk("R8 pass on golden match", 64'({pass_d, fail_d}), 64'h2);
        chk("R6 one-bit golden change gives fail", 64'({pass_b, fail_b}), 64'h1);
        chk("R10 zero generator gives fail", 64'({pass_z, fail_z}), 64'h1);
        cycles(10);
        chk("R9 verdict held while idle", 64'({pass_d, busy_d}), 64'h2);

        // run 2, request held for several cycles
        start_req = 1'b1; cycles(4); start_req = 1'b0;
        chk("R1 verdict cleared during run", 64'({pass_d, fail_d, busy_d}), 64'h1);
        cycles(70);
        chk("R8 second run pass", 64'({pass_d, fail_d}), 64'h2);
        chk("R6 second run mismatch", 64'({pass_b, fail_b}), 64'h1);
        chk("R10 second run zero seed", 64'({pass_z, fail_z}), 64'h1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(8 * 5000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog R8 actual=timeout expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule